// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps the charge in every row of a 2048-row DRAM topped up before it leaks away. A free-running timer divides the selected retention period by the row count and raises a refresh request to the memory access arbiter once per slot. When the arbiter grants the request, the block takes over the row and column strobes for one refresh cycle. That cycle has three timed phases: setup, strobe pulse and recovery.

Two refresh styles are offered. In explicit-row mode the block drives the next row number from its own wrapping counter and pulses only the row strobe. In internal-counter mode the column strobe falls before the row strobe, and the memory picks the row itself, so the address output stays at zero. When the arbiter holds off grants, up to eight missed slots are remembered. The request stays raised until all of them have been served.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and right after it, ref_req and busy are low, ras_n and cas_n are high and ref_row is zero.
- R2: The request interval in clock cycles is P*CLK_HZ/(1000*ROWS), where P is 16, 32, 64 or 128 ms for period_sel = 0, 1, 2, 3. The first request is raised exactly one interval after reset ends.
- R3: A raised request stays high until ref_gnt is seen with it. ref_req is low in every cycle in which busy is high.
- R4: With cbr_mode=0 at grant, starting in the cycle after grant: ras_n is high for SETUP_CYC cycles, low for PULSE_CYC cycles, then high for RECOV_CYC cycles. cas_n stays high throughout, and ref_row holds the row being refreshed.
- R5: With cbr_mode=1 at grant, cas_n is low for SETUP_CYC cycles before ras_n falls. Both strobes are then low for PULSE_CYC cycles and both are high during recovery. ref_row stays zero.
- R6: The row counter starts at 0 and advances by one after each explicit-row refresh, wrapping from ROWS-1 to 0. Every row is therefore visited once per ROWS refreshes, which fits within one retention period when grants are prompt. Internal-counter refreshes do not move the counter.
- R7: Missed intervals are stored as a backlog saturating at BACKLOG_MAX (8). ref_req stays high until one refresh per stored entry has been run.
- R8: busy rises in the cycle after a granted request and stays high for exactly SETUP_CYC+PULSE_CYC+RECOV_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbr_mode | input | 1 | 0 = explicit-row refresh, 1 = column-before-row refresh; sampled at grant |
| period_sel | input | 2 | Retention period: 0=16, 1=32, 2=64, 3=128 ms |
| ref_gnt | input | 1 | Grant from the access arbiter |
| ref_req | output | 1 | Refresh request to the arbiter |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ref_row | output | $clog2(ROWS) | Row address for explicit-row refresh |
| busy | output | 1 | Refresh cycle in progress |

## Verification
The in-line assertions check the following on every cycle:
- the request is never raised during a refresh;
- the column strobe precedes the row strobe in internal-counter mode and stays idle in explicit-row mode;
- the backlog never passes its ceiling;
- the row counter steps by one after each explicit-row cycle;
- busy only rises after a granted request.

Only the bench scenarios can show the following:
- the exact request spacing for each period setting;
- the per-cycle phase lengths;
- a full sweep covering all 2048 rows within one period, followed by the wrap back to row 0;
- that a stored backlog of eight is drained one refresh per entry.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned ROWS        = 2048,
  parameter int unsigned SETUP_CYC   = 1,
  parameter int unsigned PULSE_CYC   = 3,
  parameter int unsigned RECOV_CYC   = 2,
  parameter int unsigned BACKLOG_MAX = 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cbr_mode,
  input  logic [1:0]       period_sel,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] ref_row,
  output logic             busy
);
  localparam longint unsigned KHZ = longint'(CLK_HZ) / 1000;
  localparam longint unsigned IV0 = KHZ * 16  / ROWS;
  localparam longint unsigned IV1 = KHZ * 32  / ROWS;
  localparam longint unsigned IV2 = KHZ * 64  / ROWS;
  localparam longint unsigned IV3 = KHZ * 128 / ROWS;
  localparam int TW    = $clog2(IV3 + 1);
  localparam int BW    = $clog2(BACKLOG_MAX + 1);
  localparam int unsigned PH_MAX = (SETUP_CYC > PULSE_CYC) ?
      ((SETUP_CYC > RECOV_CYC) ? SETUP_CYC : RECOV_CYC) :
      ((PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC);
  localparam int CW    = $clog2(PH_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_PULSE, S_RECOV} phase_t;

  phase_t           phase;
  logic [CW-1:0]    ph_cnt;
  logic [TW-1:0]    tmr, ivl;
  logic [BW-1:0]    backlog;
  logic [ROW_W-1:0] row_cnt;
  logic             mode_q;
  logic             tick, take;

  always_comb begin
    case (period_sel)
      2'd0:    ivl = TW'(IV0);
      2'd1:    ivl = TW'(IV1);
      2'd2:    ivl = TW'(IV2);
      default: ivl = TW'(IV3);
    endcase
  end

  assign tick    = (tmr >= ivl - TW'(1));
  assign ref_req = (phase == S_IDLE) && (backlog != '0);
  assign take    = ref_req && ref_gnt;
  assign busy    = (phase != S_IDLE);
  assign ras_n   = (phase != S_PULSE);
  assign cas_n   = !(mode_q && (phase == S_SETUP || phase == S_PULSE));
  assign ref_row = (busy && !mode_q) ? row_cnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr <= '0;
    else        tmr <= tick ? '0 : tmr + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) backlog <= '0;
    else if (tick && !take && backlog != BW'(BACKLOG_MAX)) backlog <= backlog + BW'(1);
    else if (!tick && take) backlog <= backlog - BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= S_IDLE;
      ph_cnt  <= '0;
      row_cnt <= '0;
      mode_q  <= 1'b0;
    end else begin
      case (phase)
        S_IDLE: if (take) begin
          phase  <= S_SETUP;
          ph_cnt <= '0;
          mode_q <= cbr_mode;
        end
        S_SETUP: if (ph_cnt == CW'(SETUP_CYC - 1)) begin
          phase <= S_PULSE; ph_cnt <= '0;
        end else ph_cnt <= ph_cnt + CW'(1);
        S_PULSE: if (ph_cnt == CW'(PULSE_CYC - 1)) begin
          phase <= S_RECOV; ph_cnt <= '0;
        end else ph_cnt <= ph_cnt + CW'(1);
        default: if (ph_cnt == CW'(RECOV_CYC - 1)) begin
          phase  <= S_IDLE;
          ph_cnt <= '0;
          if (!mode_q)
            row_cnt <= (row_cnt == ROW_W'(ROWS - 1)) ? '0 : row_cnt + ROW_W'(1);
        end else ph_cnt <= ph_cnt + CW'(1);
      endcase
    end
  end

  assert_no_req_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ref_req);
  assert_cas_idle_row_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !mode_q) |-> cas_n);
  assert_cas_before_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && $fell(ras_n)) |-> $past(!cas_n));
  assert_no_addr_cbr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> (ref_row == '0));
  assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !mode_q) |->
      (row_cnt == (($past(row_cnt) == ROW_W'(ROWS - 1)) ? '0 : $past(row_cnt) + ROW_W'(1))));
  assert_backlog_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= BW'(BACKLOG_MAX));
  assert_busy_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ref_req && ref_gnt));
endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb_top;
  localparam int unsigned ROWS = 2048;
  localparam int unsigned SU = 1, PW = 2, RC = 2;
  localparam int RW = $clog2(ROWS);

  logic clk = 1'b0, rst_n = 1'b0, cbr_mode = 1'b0, ref_gnt = 1'b0;
  logic [1:0] period_sel = 2'd0;
  logic ref_req, ras_n, cas_n, busy;
  logic [RW-1:0] ref_row;
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(negedge clk) cyc++;

  dram_refresh_sched #(.CLK_HZ(2_048_000), .ROWS(ROWS), .SETUP_CYC(SU),
                       .PULSE_CYC(PW), .RECOV_CYC(RC), .BACKLOG_MAX(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .period_sel(period_sel),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n),
    .ref_row(ref_row), .busy(busy));

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit m, input logic [1:0] sel);
    rst_n = 1'b0; ref_gnt = 1'b0; cbr_mode = m; period_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_ref(input bit m, input int exp_row, input bit loud, output int errs);
    int n = 0;
    errs = 0;
    while (!ref_req && n < 1000) begin @(negedge clk); n++; end
    if (loud) check(ref_req, "R3", "request seen before grant", int'(ref_req), 1);
    cbr_mode = m;
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    for (int k = 0; k < int'(SU + PW + RC); k++) begin
      bit e_ras = !(k >= int'(SU) && k < int'(SU + PW));
      bit e_cas = !(m && k < int'(SU + PW));
      int e_row = m ? 0 : exp_row;
      string rq = m ? "R5" : "R4";
      if (loud) begin
        check(busy == 1'b1, "R8", "busy during cycle", int'(busy), 1);
        check(ref_req == 1'b0, "R3", "req while busy", int'(ref_req), 0);
        check(ras_n == e_ras, rq, $sformatf("ras_n at phase cycle %0d", k), int'(ras_n), int'(e_ras));
        check(cas_n == e_cas, rq, $sformatf("cas_n at phase cycle %0d", k), int'(cas_n), int'(e_cas));
        check(int'(ref_row) == e_row, rq, "ref_row", int'(ref_row), e_row);
      end else if (!busy || ras_n != e_ras || cas_n != e_cas || int'(ref_row) != e_row)
        errs++;
      @(negedge clk);
    end
    if (loud) check(busy == 1'b0, "R8", "busy after recovery", int'(busy), 0);
    else if (busy) errs++;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ref_gnt = 1'b0;
    repeat (2) @(negedge clk);
    check(!ref_req && !busy && ras_n && cas_n && ref_row == '0, "R1", "outputs in reset",
          {ref_req, busy, ras_n, cas_n}, 4'b0011);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ref_req && !busy && ras_n && cas_n, "R1", "outputs after reset",
          {ref_req, busy, ras_n, cas_n}, 4'b0011);
  endtask

  task automatic t_interval(input logic [1:0] sel);
    int n = 0;
    do_reset(1'b0, sel);
    do begin @(negedge clk); n++; end while (!ref_req && n < 1000);
    check(n == (16 << sel), "R2", $sformatf("first request spacing sel=%0d", sel), n, 16 << sel);
  endtask

  task automatic t_row_cycle;
    int e;
    do_reset(1'b0, 2'd0);
    repeat (20) @(negedge clk);
    check(ref_req == 1'b1, "R3", "request held without grant", int'(ref_req), 1);
    do_ref(1'b0, 0, 1'b1, e);
  endtask

  task automatic t_cbr;
    int e;
    do_reset(1'b1, 2'd0);
    do_ref(1'b1, 0, 1'b1, e);
    do_ref(1'b0, 0, 1'b1, e);
    check(e == 0, "R6", "row counter unmoved by column-first refresh", e, 0);
  endtask

  task automatic t_sweep;
    int e, errs = 0, t0 = 0, t1 = 0;
    do_reset(1'b0, 2'd0);
    for (int i = 0; i < int'(ROWS); i++) begin
      if (i == 0) t0 = cyc;
      if (i == int'(ROWS) - 1) t1 = cyc;
      do_ref(1'b0, i, 1'b0, e);
      errs += e;
    end
    check(errs == 0, "R6", "rows visited in order", errs, 0);
    check(t1 - t0 < int'(ROWS) * 16, "R6", "full sweep within one period", t1 - t0, int'(ROWS) * 16);
    do_ref(1'b0, 0, 1'b1, e);
    do_ref(1'b1, 0, 1'b1, e);
    do_ref(1'b0, 1, 1'b1, e);
  endtask

  task automatic t_backlog;
    int served = 0;
    bit prev = 0;
    do_reset(1'b0, 2'd3);
    repeat (128 * 10 + 5) @(negedge clk);
    check(ref_req == 1'b1, "R7", "request pending after missed slots", int'(ref_req), 1);
    ref_gnt = 1'b1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (busy && !prev) served++;
      prev = busy;
    end
    ref_gnt = 1'b0;
    check(served == 8, "R7", "refreshes served from saturated backlog", served, 8);
    check(ref_req == 1'b0, "R7", "request cleared once backlog drained", int'(ref_req), 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset;
    for (int s = 0; s < 4; s++) t_interval(2'(s));
    t_row_cycle;
    t_cbr;
    t_backlog;
    t_sweep;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule